// File: doc/BRIEF.md
# Per-Core MSI Vector Interrupt Controller

This block accepts message-signalled interrupt writes and turns each one into a pending bit in a per-core array of 256 vectors. The write carries no payload. The target core and the vector are both encoded in the write address: bits [11:4] hold the vector and bits [27:12] hold the physical ID of the core. Bits [31:28] must match a fixed window tag. Each core drives one interrupt line toward its CPU. The line stays high while that core has any pending vector and delivery is enabled.

Software on a core services an interrupt in three steps. It issues a claim, which selects the highest-numbered pending vector, retires it from the pending set and marks it in service. It reads the claim result, which gives the vector in bits [7:0] or sets bit 31 when nothing was pending. When the handler finishes, it posts an end-of-service write naming the vector. The in-service set of any core can be read as four 64-bit words. Vector v appears in word v/64 at bit v%64.

A two-state delivery controller follows the global enable input. The state `CTL_OFF` is the reset state. The transition `T_ARM` moves the controller to `CTL_RUN` when the enable is sampled high. The transition `T_DISARM` returns it to `CTL_OFF` when the enable is sampled low. In every other cycle the controller holds its state. Messages are only latched in `CTL_RUN`, and the interrupt lines are forced low in `CTL_OFF`. Messages that name a core that does not exist set a sticky error flag. Messages that use one of the reserved vectors 0 to 15 are latched as normal but are counted.

Top module: `msivec_top`

## Requirements
- R1: A write with `msg_valid` high, address bits [31:28] equal to `WIN_TAG`, core ID (bits [27:12]) below `NUM_CORES` and vector in bits [11:4] sets that vector's pending bit in that core while the controller is in `CTL_RUN`. The core's `irq_out` bit is high after the clock edge that takes the write.
- R2: `msg_data` has no effect on any output.
- R3: The controller enters `CTL_RUN` on the edge that samples `deliver_en` high and enters `CTL_OFF` on the edge that samples it low. In `CTL_OFF`, messages are discarded and `irq_out` is all zero. Claims still operate in `CTL_OFF`.
- R4: A claim (`claim_req`, core `claim_core`) with pending vectors loads `claim_rdata` on that edge with the highest pending vector in bits [7:0] and zero in bits [31:8]. The same edge clears that vector's pending bit and sets its in-service bit. `claim_rdata` holds its value between claims.
- R5: A claim when no vector is pending, or one that names a nonexistent core, loads `claim_rdata` with 32'h8000_0000. This is also the reset value.
- R6: `isr_rdata` shows word `isr_sel` of core `isr_core`'s in-service set, with vector v at bit v%64 of word v/64.
- R7: An end-of-service write (`eoi_valid`, `eoi_core`, `eoi_vec`) clears that vector's in-service bit and leaves the other in-service bits unchanged.
- R8: Signalling a vector again while it is already pending leaves a single pending entry, so it is claimed once only.
- R9: An in-window message whose core ID is `NUM_CORES` or above is dropped and sets `bad_core_err`, which stays set until reset.
- R10: A message that is latched with a vector below 16 sets its pending bit like any other and increments `legacy_cnt`, which saturates at its maximum value.
- R11: A write whose bits [31:28] differ from `WIN_TAG` is ignored.
- R12: `irq_out` for a core stays high while any of its vectors is pending and falls after the claim that retires the last one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| deliver_en | input | 1 | Global delivery enable |
| msg_valid | input | 1 | Message write strobe |
| msg_addr | input | 32 | Message address: tag, core ID, vector |
| msg_data | input | 32 | Message data, ignored |
| claim_req | input | 1 | Claim strobe |
| claim_core | input | CORE_W | Core whose vector is claimed |
| claim_rdata | output | 32 | Claim result: vector [7:0], invalid flag [31] |
| eoi_valid | input | 1 | End-of-service strobe |
| eoi_core | input | CORE_W | Core of the end-of-service write |
| eoi_vec | input | 8 | Vector leaving service |
| isr_core | input | CORE_W | Core whose in-service set is read |
| isr_sel | input | 2 | In-service word select |
| isr_rdata | output | 64 | Selected in-service word |
| irq_out | output | NUM_CORES | One interrupt line per core |
| bad_core_err | output | 1 | Sticky error for a nonexistent core |
| legacy_cnt | output | LEG_CNT_W | Saturating count of reserved-vector messages |

## Verification
The bench builds the block with `NUM_CORES` set to 3. This leaves core ID 3 within the 2-bit select range but outside the core set, so the nonexistent-core path can be driven both through a message and through a claim. It sets `LEG_CNT_W` to 2, so the reserved-vector counter reaches saturation after three messages and a fourth message shows that it holds. Vectors in words 1 and 3 of the in-service set are used to exercise the word selection away from word 0.

// File: rtl/msivec_pkg.sv
package msivec_pkg;

    localparam int VEC_W       = 8;
    localparam int NUM_VEC     = 1 << VEC_W;
    localparam int WORD_W      = 64;
    localparam int NUM_WORDS   = NUM_VEC / WORD_W;
    localparam int SEL_W       = $clog2(NUM_WORDS);
    localparam int ADDR_W      = 32;
    localparam int ID_W        = 16;
    localparam int TAG_W       = 4;
    localparam int VEC_LSB     = 4;
    localparam int ID_LSB      = VEC_LSB + VEC_W;
    localparam int TAG_LSB     = ID_LSB + ID_W;
    localparam int RESERVED_N  = 16;
    localparam int CLAIM_W     = 32;
    localparam int INVALID_BIT = 31;

    typedef enum logic [0:0] {
        CTL_OFF = 1'b0,
        CTL_RUN = 1'b1
    } ctl_state_t;

    typedef struct packed {
        logic             in_window;
        logic             bad_core;
        logic             reserved;
        logic [ID_W-1:0]  core_id;
        logic [VEC_W-1:0] vec;
    } msg_dec_t;

    function automatic logic [CLAIM_W-1:0] claim_word(input logic found,
                                                      input logic [VEC_W-1:0] vec);
        logic [CLAIM_W-1:0] w;
        w = '0;
        if (found) w[VEC_W-1:0] = vec;
        else       w[INVALID_BIT] = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/msivec_ctl.sv
module msivec_ctl
    import msivec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic deliver_en,
    output logic run
);

    ctl_state_t state_q;
    ctl_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CTL_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CTL_OFF: if (deliver_en)  state_d = CTL_RUN;   // T_ARM
            CTL_RUN: if (!deliver_en) state_d = CTL_OFF;   // T_DISARM
        endcase
    end

    always_comb begin
        run = 1'b0;
        unique case (state_q)
            CTL_OFF: run = 1'b0;
            CTL_RUN: run = 1'b1;
        endcase
    end

endmodule

// File: rtl/msivec_decode.sv
module msivec_decode
    import msivec_pkg::*;
#(
    parameter int         NUM_CORES = 4,
    parameter logic [3:0] WIN_TAG   = 4'h1
) (
    input  logic              msg_valid,
    input  logic [ADDR_W-1:0] msg_addr,
    output msg_dec_t          dec
);

    always_comb begin
        dec.core_id   = msg_addr[ID_LSB +: ID_W];
        dec.vec       = msg_addr[VEC_LSB +: VEC_W];
        dec.in_window = msg_valid && (msg_addr[TAG_LSB +: TAG_W] == WIN_TAG);
        dec.bad_core  = dec.in_window && (int'(dec.core_id) >= NUM_CORES);
        dec.reserved  = (int'(dec.vec) < RESERVED_N);
    end

endmodule

// File: rtl/msivec_prio.sv
module msivec_prio #(
    parameter int N  = 256,
    parameter int IW = 8
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/msivec_bank.sv
module msivec_bank
    import msivec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [VEC_W-1:0]  set_vec,
    input  logic              clm_en,
    input  logic              eoi_en,
    input  logic [VEC_W-1:0]  eoi_vec,
    input  logic [SEL_W-1:0]  word_sel,
    output logic              pend_any,
    output logic [VEC_W-1:0]  top_vec,
    output logic [WORD_W-1:0] insvc_word
);

    logic [NUM_VEC-1:0] pend_q, pend_d;
    logic [NUM_VEC-1:0] insvc_q, insvc_d;

    msivec_prio #(.N(NUM_VEC), .IW(VEC_W)) u_prio (
        .req (pend_q),
        .any (pend_any),
        .idx (top_vec)
    );

    always_comb begin
        pend_d  = pend_q;
        insvc_d = insvc_q;
        if (eoi_en)
            insvc_d[eoi_vec] = 1'b0;
        if (clm_en && pend_any) begin
            pend_d[top_vec]  = 1'b0;
            insvc_d[top_vec] = 1'b1;
        end
        if (set_en)
            pend_d[set_vec] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q  <= '0;
            insvc_q <= '0;
        end else begin
            pend_q  <= pend_d;
            insvc_q <= insvc_d;
        end
    end

    assign insvc_word = insvc_q[word_sel*WORD_W +: WORD_W];

endmodule

// File: rtl/msivec_top.sv
module msivec_top
    import msivec_pkg::*;
#(
    parameter int         NUM_CORES = 4,
    parameter logic [3:0] WIN_TAG   = 4'h1,
    parameter int         LEG_CNT_W = 8,
    localparam int        CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 deliver_en,
    input  logic                 msg_valid,
    input  logic [31:0]          msg_addr,
    input  logic [31:0]          msg_data,
    input  logic                 claim_req,
    input  logic [CORE_W-1:0]    claim_core,
    output logic [31:0]          claim_rdata,
    input  logic                 eoi_valid,
    input  logic [CORE_W-1:0]    eoi_core,
    input  logic [7:0]           eoi_vec,
    input  logic [CORE_W-1:0]    isr_core,
    input  logic [1:0]           isr_sel,
    output logic [63:0]          isr_rdata,
    output logic [NUM_CORES-1:0] irq_out,
    output logic                 bad_core_err,
    output logic [LEG_CNT_W-1:0] legacy_cnt
);

    localparam logic [LEG_CNT_W-1:0] LEG_MAX = '1;

    logic     run;
    msg_dec_t dec;
    logic     accept;

    logic [NUM_CORES-1:0] any_v;
    logic [VEC_W-1:0]     vec_v  [NUM_CORES];
    logic [WORD_W-1:0]    word_v [NUM_CORES];

    logic             sel_any;
    logic [VEC_W-1:0] sel_vec;

    msivec_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .deliver_en (deliver_en),
        .run        (run)
    );

    msivec_decode #(.NUM_CORES(NUM_CORES), .WIN_TAG(WIN_TAG)) u_dec (
        .msg_valid (msg_valid),
        .msg_addr  (msg_addr),
        .dec       (dec)
    );

    assign accept = run && dec.in_window && !dec.bad_core;

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
        msivec_bank u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .set_en     (accept && (int'(dec.core_id) == g)),
            .set_vec    (dec.vec),
            .clm_en     (claim_req && (int'(claim_core) == g)),
            .eoi_en     (eoi_valid && (int'(eoi_core) == g)),
            .eoi_vec    (eoi_vec),
            .word_sel   (isr_sel),
            .pend_any   (any_v[g]),
            .top_vec    (vec_v[g]),
            .insvc_word (word_v[g])
        );
        assign irq_out[g] = run && any_v[g];
    end

    always_comb begin
        sel_any   = 1'b0;
        sel_vec   = '0;
        isr_rdata = '0;
        for (int c = 0; c < NUM_CORES; c++) begin
            if (int'(claim_core) == c) begin
                sel_any = any_v[c];
                sel_vec = vec_v[c];
            end
            if (int'(isr_core) == c)
                isr_rdata = word_v[c];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            claim_rdata  <= claim_word(1'b0, '0);
            bad_core_err <= 1'b0;
            legacy_cnt   <= '0;
        end else begin
            if (claim_req)
                claim_rdata <= claim_word(sel_any, sel_vec);
            if (dec.bad_core)
                bad_core_err <= 1'b1;
            if (accept && dec.reserved && (legacy_cnt != LEG_MAX))
                legacy_cnt <= legacy_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/msivec_chk.sv
module msivec_chk #(
    parameter int NUM_CORES = 4,
    parameter int LEG_CNT_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 deliver_en,
    input logic                 claim_req,
    input logic [31:0]          claim_rdata,
    input logic [NUM_CORES-1:0] irq_out,
    input logic                 bad_core_err,
    input logic [LEG_CNT_W-1:0] legacy_cnt
);

    assert_irq_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(deliver_en) |-> (irq_out == '0));

    assert_claim_format_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(claim_req) |-> (claim_rdata[30:8] == '0));

    assert_claim_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(claim_req) |-> $stable(claim_rdata));

    assert_invalid_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
        claim_rdata[31] |-> (claim_rdata[7:0] == '0));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bad_core_err) |-> bad_core_err);

    assert_legacy_monotonic_R10: assert property (@(posedge clk) disable iff (!rst_n)
        legacy_cnt >= $past(legacy_cnt));

endmodule

bind msivec_top msivec_chk #(.NUM_CORES(NUM_CORES), .LEG_CNT_W(LEG_CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .deliver_en   (deliver_en),
    .claim_req    (claim_req),
    .claim_rdata  (claim_rdata),
    .irq_out      (irq_out),
    .bad_core_err (bad_core_err),
    .legacy_cnt   (legacy_cnt)
);

// File: tb/tb_msivec_top.sv
`timescale 1ns/1ps
module tb_msivec_top;

    localparam int         NC   = 3;
    localparam int         CW   = 2;
    localparam int         LW   = 2;
    localparam logic [3:0] TAG  = 4'h1;
    localparam logic [31:0] INV = 32'h8000_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          deliver_en = 1'b0;
    logic          msg_valid = 1'b0;
    logic [31:0]   msg_addr = '0;
    logic [31:0]   msg_data = '0;
    logic          claim_req = 1'b0;
    logic [CW-1:0] claim_core = '0;
    logic [31:0]   claim_rdata;
    logic          eoi_valid = 1'b0;
    logic [CW-1:0] eoi_core = '0;
    logic [7:0]    eoi_vec = '0;
    logic [CW-1:0] isr_core = '0;
    logic [1:0]    isr_sel = '0;
    logic [63:0]   isr_rdata;
    logic [NC-1:0] irq_out;
    logic          bad_core_err;
    logic [LW-1:0] legacy_cnt;

    int n_checks = 0;
    int n_fails  = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rsp_pend = 1'b0;

    always #2.5 clk = ~clk;

    msivec_top #(.NUM_CORES(NC), .WIN_TAG(TAG), .LEG_CNT_W(LW)) dut (
        .clk(clk), .rst_n(rst_n), .deliver_en(deliver_en),
        .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data),
        .claim_req(claim_req), .claim_core(claim_core), .claim_rdata(claim_rdata),
        .eoi_valid(eoi_valid), .eoi_core(eoi_core), .eoi_vec(eoi_vec),
        .isr_core(isr_core), .isr_sel(isr_sel), .isr_rdata(isr_rdata),
        .irq_out(irq_out), .bad_core_err(bad_core_err), .legacy_cnt(legacy_cnt)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // scoreboard monitor: compares every claim response
    always @(posedge clk) rsp_pend <= claim_req;

    always @(negedge clk) begin
        if (rsp_pend) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fails++;
                $display("FAIL claim: actual %h expected none", claim_rdata);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (claim_rdata !== e) begin
                    n_fails++;
                    $display("FAIL %s: actual %h expected %h", t, claim_rdata, e);
                end
            end
        end
    end

    task automatic send(input int core, input int vec, input logic [31:0] data,
                        input logic [3:0] tg);
        @(negedge clk);
        msg_valid = 1'b1;
        msg_addr  = {tg, 16'(core), 8'(vec), 4'h0};
        msg_data  = data;
        @(negedge clk);
        msg_valid = 1'b0;
        msg_data  = '0;
    endtask

    task automatic claim(input int core, input logic [31:0] exp, input string tg);
        @(negedge clk);
        claim_req  = 1'b1;
        claim_core = CW'(core);
        exp_q.push_back(exp);
        tag_q.push_back(tg);
        @(negedge clk);
        claim_req = 1'b0;
    endtask

    task automatic eoi(input int core, input int vec);
        @(negedge clk);
        eoi_valid = 1'b1;
        eoi_core  = CW'(core);
        eoi_vec   = 8'(vec);
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    task automatic read_isr(input int core, input int word, output logic [63:0] val);
        isr_core = CW'(core);
        isr_sel  = 2'(word);
        #0.5;
        val = isr_rdata;
    endtask

    function automatic logic [31:0] vw(input int v);
        return {24'b0, 8'(v)};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fails, n_checks + 1);
        $finish;
    end

    initial begin
        logic [63:0] w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R5, R9, R10, R12)
        chk("R5 reset claim word", claim_rdata, INV);
        chk("R12 reset irq", irq_out, 0);
        chk("R9 reset err", bad_core_err, 0);
        chk("R10 reset count", legacy_cnt, 0);

        // delivery off: message discarded (R3)
        send(0, 40, 0, TAG);
        chk("R3 irq low while off", irq_out, 0);
        deliver_en = 1'b1;
        repeat (2) @(negedge clk);
        claim(0, INV, "R3 message dropped while off");

        // delivery, data ignored, merge, priority
        send(1, 200, 32'hFFFF_FFFF, TAG);
        chk("R1 irq after write", irq_out, 3'b010);
        send(1, 77, 0, TAG);
        send(1, 200, 0, TAG);
        claim(1, vw(200), "R4 highest vector, R2 data ignored");
        read_isr(1, 3, w);
        chk("R6 in-service word 3", w, 64'd1 << 8);
        chk("R12 irq held while pending", irq_out, 3'b010);
        claim(1, vw(77), "R4 next vector");
        chk("R12 irq falls after last claim", irq_out, 0);
        claim(1, INV, "R8 merged vector claimed once");
        read_isr(1, 1, w);
        chk("R6 in-service word 1", w, 64'd1 << 13);
        eoi(1, 200);
        read_isr(1, 3, w);
        chk("R7 eoi clears bit", w, 0);
        read_isr(1, 1, w);
        chk("R7 other bit kept", w, 64'd1 << 13);

        // nonexistent core (R9, R5)
        send(3, 50, 0, TAG);
        chk("R9 err set", bad_core_err, 1);
        chk("R9 message dropped", irq_out, 0);
        claim(3, INV, "R5 claim nonexistent core");
        send(0, 20, 0, TAG);
        chk("R9 err sticky", bad_core_err, 1);

        // reserved vectors (R10)
        send(2, 5, 0, TAG);
        chk("R10 count one", legacy_cnt, 1);
        chk("R10 reserved latched irq", irq_out, 3'b101);
        claim(2, vw(5), "R10 reserved vector latched");
        send(2, 3, 0, TAG);
        send(2, 3, 0, TAG);
        send(2, 3, 0, TAG);
        chk("R10 count saturates", legacy_cnt, 3);
        claim(2, vw(3), "R10 reserved vector claim");
        claim(2, INV, "R8 reserved merge");

        // out-of-window write ignored (R11)
        send(0, 99, 0, 4'h7);
        claim(0, vw(20), "R11 foreign window ignored");
        claim(0, INV, "R11 nothing else pending");

        // data word ignored (R2)
        send(0, 33, 32'hDEAD_BEEF, TAG);
        claim(0, vw(33), "R2 data ignored");

        // disable with a pending vector (R3)
        send(0, 60, 0, TAG);
        chk("R1 irq core0", irq_out, 3'b001);
        deliver_en = 1'b0;
        @(negedge clk);
        chk("R3 irq forced low", irq_out, 0);
        claim(0, vw(60), "R3 claim works while off");
        @(negedge clk);
        chk("R4 scoreboard drained", exp_q.size(), 0);

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule